// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Held Start

This block buffers stereo audio samples between a processor write port and a serial audio output stage. Software pushes samples one per cycle in short bursts. A word-clock frame strobe takes one stereo sample per frame and places it on the registered transmit outputs.

The start-up is unusual. After hardware reset, or while and after the software reset input is raised, the FIFO is flushed and primed with a single all-zero sample. It then sits in a held state, where frame strobes have no effect. The first accepted data write ends the hold, and from then on each frame strobe drains one sample. A typical first burst of 2, 3 or 4 samples therefore leaves 3, 4 or 5 entries. Sticky status flags report empty, underrun and overflow.

Top module: `audio_tx_fifo`

## Requirements
- R1: After `rst_ni` is released, `count_o` is 1, `running_o` is 0, all three flags are 0 and both transmit outputs are 0.
- R2: While held (`running_o`=0), a frame strobe does not change `count_o`, the transmit outputs or any flag.
- R3: An accepted write while held sets `running_o` from the next cycle. Each accepted write raises `count_o` by one, starting from the single primed entry.
- R4: While running, a frame strobe with `count_o`>0 pops the oldest entry onto `tx_left_o`/`tx_right_o` after that edge. Order is first in, first out, and the first value popped after a start is the all-zero primed sample.
- R5: While running, a frame strobe with `count_o`=0 sets `underrun_o`, drives zero on both transmit outputs and leaves `count_o` at 0.
- R6: `underrun_o` stays set until `clr_underrun_i` is pulsed. If a new underrun occurs in the same cycle as the clear, the flag stays set.
- R7: `empty_o` is set when a pop leaves the FIFO with no entries, or when an underrun occurs. It stays set until the next accepted data write clears it.
- R8: The capacity is 6 entries, and `count_o` never exceeds it. A write arriving when `count_o` is 6 is dropped and its data never reaches the outputs. Such a write sets the sticky `overflow_o`, which only `clr_overflow_i` clears.
- R9: While `soft_rst_i` is high, the FIFO is flushed. On the next cycle `count_o` is 1, `running_o` is 0, flags and transmit outputs are 0, and any write in that cycle is ignored.
- R10: While running, a write and a frame strobe in the same cycle both take effect, and `count_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software flush; returns to held state |
| wr_valid_i | input | 1 | Push one stereo sample |
| wr_left_i | input | W | Left sample data |
| wr_right_i | input | W | Right sample data |
| frame_i | input | 1 | Word-clock frame strobe |
| clr_underrun_i | input | 1 | Clear underrun flag |
| clr_overflow_i | input | 1 | Clear overflow flag |
| tx_left_o | output | W | Left sample to transmitter |
| tx_right_o | output | W | Right sample to transmitter |
| count_o | output | clog2(DEPTH+1) | Entries held |
| running_o | output | 1 | Draining enabled |
| empty_o | output | 1 | Sticky empty flag |
| underrun_o | output | 1 | Sticky underrun flag |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
On every cycle the assertions check these properties:
- the capacity bound;
- that a held FIFO neither drains nor moves its outputs;
- that a write ends the hold;
- that an underrun raises its flag with zero output;
- the stickiness of underrun;
- that a write clears empty;
- that a software reset returns the FIFO to one held entry.

Only the bench scenarios can show the properties that depend on data:
- that the primed zero sample comes out first;
- first-in first-out ordering across wrap of the storage;
- that a dropped overflow write never appears at the output;
- that a simultaneous write and pop leave the count unchanged.

// File: rtl/audio_txf_pkg.sv
package audio_txf_pkg;
  typedef enum logic {
    ST_HELD = 1'b0,
    ST_RUN  = 1'b1
  } txf_state_e;
endpackage

// File: rtl/audio_txf_store.sv
module audio_txf_store #(
  parameter int W     = 16,
  parameter int DEPTH = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wr_l_i,
  input  logic [W-1:0] wr_r_i,
  output logic [W-1:0] head_l_o,
  output logic [W-1:0] head_r_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_l [DEPTH];
  logic [W-1:0]     mem_r [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // entry 0 doubles as the zero primed sample after any flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_l[i] <= '0;
        mem_r[i] <= '0;
      end
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_l[i] <= '0;
        mem_r[i] <= '0;
      end
    end else if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_ptr_q == PTR_W'(i)) begin
          mem_l[i] <= wr_l_i;
          mem_r[i] <= wr_r_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= PTR_W'(1 % DEPTH);
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= PTR_W'(1 % DEPTH);
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
    end
  end

  assign head_l_o = mem_l[rd_ptr_q];
  assign head_r_o = mem_r[rd_ptr_q];
endmodule

// File: rtl/audio_txf_ctrl.sv
module audio_txf_ctrl
  import audio_txf_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             wr_valid_i,
  input  logic             frame_i,
  input  logic             clr_underrun_i,
  input  logic             clr_overflow_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             flush_o,
  output logic             udr_evt_o,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             empty_o,
  output logic             underrun_o,
  output logic             overflow_o
);
  txf_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic             empty_q, udr_q, ovf_q;
  logic             full, none, ovf_evt;

  assign full      = (count_q == CNT_W'(DEPTH));
  assign none      = (count_q == '0);
  assign flush_o   = soft_rst_i;
  assign push_o    = !soft_rst_i && wr_valid_i && !full;
  assign ovf_evt   = !soft_rst_i && wr_valid_i && full;
  assign pop_o     = !soft_rst_i && (state_q == ST_RUN) && frame_i && !none;
  assign udr_evt_o = !soft_rst_i && (state_q == ST_RUN) && frame_i && none;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HELD;
      count_q <= CNT_W'(1);
      empty_q <= 1'b0;
      udr_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= ST_HELD;
      count_q <= CNT_W'(1);
      empty_q <= 1'b0;
      udr_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (push_o) state_q <= ST_RUN;
      count_q <= count_q + CNT_W'(push_o) - CNT_W'(pop_o);
      if (push_o)                                         empty_q <= 1'b0;
      else if ((pop_o && count_q == CNT_W'(1)) || udr_evt_o) empty_q <= 1'b1;
      // a fresh event outranks the clear
      if (udr_evt_o)           udr_q <= 1'b1;
      else if (clr_underrun_i) udr_q <= 1'b0;
      if (ovf_evt)             ovf_q <= 1'b1;
      else if (clr_overflow_i) ovf_q <= 1'b0;
    end
  end

  assign count_o    = count_q;
  assign running_o  = (state_q == ST_RUN);
  assign empty_o    = empty_q;
  assign underrun_o = udr_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       soft_rst_i,
  input  logic                       wr_valid_i,
  input  logic [W-1:0]               wr_left_i,
  input  logic [W-1:0]               wr_right_i,
  input  logic                       frame_i,
  input  logic                       clr_underrun_i,
  input  logic                       clr_overflow_i,
  output logic [W-1:0]               tx_left_o,
  output logic [W-1:0]               tx_right_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       running_o,
  output logic                       empty_o,
  output logic                       underrun_o,
  output logic                       overflow_o
);
  logic         push, pop, flush, udr_evt;
  logic [W-1:0] head_l, head_r;

  audio_txf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .soft_rst_i     (soft_rst_i),
    .wr_valid_i     (wr_valid_i),
    .frame_i        (frame_i),
    .clr_underrun_i (clr_underrun_i),
    .clr_overflow_i (clr_overflow_i),
    .push_o         (push),
    .pop_o          (pop),
    .flush_o        (flush),
    .udr_evt_o      (udr_evt),
    .count_o        (count_o),
    .running_o      (running_o),
    .empty_o        (empty_o),
    .underrun_o     (underrun_o),
    .overflow_o     (overflow_o)
  );

  audio_txf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .push_i   (push),
    .pop_i    (pop),
    .wr_l_i   (wr_left_i),
    .wr_r_i   (wr_right_i),
    .head_l_o (head_l),
    .head_r_o (head_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_left_o  <= '0;
      tx_right_o <= '0;
    end else if (flush || udr_evt) begin
      tx_left_o  <= '0;
      tx_right_o <= '0;
    end else if (pop) begin
      tx_left_o  <= head_l;
      tx_right_o <= head_r;
    end
  end
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       soft_rst_i,
  input logic                       wr_valid_i,
  input logic                       frame_i,
  input logic                       clr_underrun_i,
  input logic [W-1:0]               tx_left_o,
  input logic [W-1:0]               tx_right_o,
  input logic [$clog2(DEPTH+1)-1:0] count_o,
  input logic                       running_o,
  input logic                       empty_o,
  input logic                       underrun_o
);
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= ($clog2(DEPTH+1))'(DEPTH));

  a_r2_held_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !wr_valid_i && !soft_rst_i) |=>
      (count_o == $past(count_o)) && $stable(tx_left_o) && !underrun_o);

  a_r3_write_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && wr_valid_i && !soft_rst_i) |=> running_o);

  a_r5_underrun_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && frame_i && count_o == '0 && !soft_rst_i) |=>
      (underrun_o && tx_left_o == '0 && tx_right_o == '0 && count_o == '0));

  a_r6_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !clr_underrun_i && !soft_rst_i) |=> underrun_o);

  a_r7_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !soft_rst_i && count_o != ($clog2(DEPTH+1))'(DEPTH)) |=> !empty_o);

  a_r9_soft_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (count_o == ($clog2(DEPTH+1))'(1) && !running_o && !underrun_o && !empty_o));
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .soft_rst_i     (soft_rst_i),
  .wr_valid_i     (wr_valid_i),
  .frame_i        (frame_i),
  .clr_underrun_i (clr_underrun_i),
  .tx_left_o      (tx_left_o),
  .tx_right_o     (tx_right_o),
  .count_o        (count_o),
  .running_o      (running_o),
  .empty_o        (empty_o),
  .underrun_o     (underrun_o)
);

// File: tb/tb_audio_tx_fifo.sv
`timescale 1ns/1ps
module tb_audio_tx_fifo;
  localparam int W = 16;
  localparam int DEPTH = 6;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [W-1:0] RMASK = 16'hA5A5;

  // {op[2:0], data[15:0], exp_cnt[3:0], exp_tx_left[15:0], exp_empty, exp_udr, exp_run}
  // op: 0 idle, 1 write, 2 frame, 3 write+frame, 4 clear underrun
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {3'd2, 16'h0000, 4'd1, 16'h0000, 3'b000},
    {3'd1, 16'h1111, 4'd2, 16'h0000, 3'b001},
    {3'd1, 16'h2222, 4'd3, 16'h0000, 3'b001},
    {3'd1, 16'h3333, 4'd4, 16'h0000, 3'b001},
    {3'd2, 16'h0000, 4'd3, 16'h0000, 3'b001},
    {3'd2, 16'h0000, 4'd2, 16'h1111, 3'b001},
    {3'd3, 16'h4444, 4'd2, 16'h2222, 3'b001},
    {3'd2, 16'h0000, 4'd1, 16'h3333, 3'b001},
    {3'd2, 16'h0000, 4'd0, 16'h4444, 3'b101},
    {3'd2, 16'h0000, 4'd0, 16'h0000, 3'b111},
    {3'd4, 16'h0000, 4'd0, 16'h0000, 3'b101},
    {3'd1, 16'h5555, 4'd1, 16'h0000, 3'b001}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          soft_rst_i = 1'b0, wr_valid_i = 1'b0, frame_i = 1'b0;
  logic          clr_underrun_i = 1'b0, clr_overflow_i = 1'b0;
  logic [W-1:0]  wr_left_i = '0, wr_right_i = '0;
  logic [W-1:0]  tx_left_o, tx_right_o;
  logic [CW-1:0] count_o;
  logic          running_o, empty_o, underrun_o, overflow_o;
  int            checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  audio_tx_fifo #(.W(W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_valid_i(wr_valid_i), .wr_left_i(wr_left_i), .wr_right_i(wr_right_i),
    .frame_i(frame_i), .clr_underrun_i(clr_underrun_i), .clr_overflow_i(clr_overflow_i),
    .tx_left_o(tx_left_o), .tx_right_o(tx_right_o), .count_o(count_o),
    .running_o(running_o), .empty_o(empty_o), .underrun_o(underrun_o),
    .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [W-1:0] d, input logic fr,
                      input logic cu, input logic co, input logic sr);
    wr_valid_i = wr; wr_left_i = d; wr_right_i = d ^ RMASK;
    frame_i = fr; clr_underrun_i = cu; clr_overflow_i = co; soft_rst_i = sr;
    @(posedge clk); #1;
    wr_valid_i = 0; frame_i = 0; clr_underrun_i = 0; clr_overflow_i = 0; soft_rst_i = 0;
  endtask

  task automatic chk_tx(input string req, input logic [W-1:0] l);
    chk(req, 32'(tx_left_o), 32'(l));
    chk(req, 32'(tx_right_o), 32'((l == '0) ? '0 : (l ^ RMASK)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 count", 32'(count_o), 1);
    chk("R1 running", 32'(running_o), 0);
    chk("R1 flags", {29'd0, empty_o, underrun_o, overflow_o}, 0);
    chk_tx("R1 tx", '0);

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][41:39];
      step(op == 3'd1 || op == 3'd3, VEC[i][38:23], op == 3'd2 || op == 3'd3,
           op == 3'd4, 1'b0, 1'b0);
      chk($sformatf("R4/R10 vec%0d count", i), 32'(count_o), 32'(VEC[i][22:19]));
      chk_tx($sformatf("R4/R5 vec%0d tx", i), VEC[i][18:3]);
      chk($sformatf("R7/R6/R3 vec%0d flags", i), {29'd0, empty_o, underrun_o, running_o},
          32'(VEC[i][2:0]));
    end

    // R8 fill to capacity, then drop one write
    for (int k = 1; k <= 5; k++) step(1, 16'h6000 + 16'(k), 0, 0, 0, 0);
    chk("R8 full count", 32'(count_o), 6);
    step(1, 16'h7777, 0, 0, 0, 0);
    chk("R8 drop count", 32'(count_o), 6);
    chk("R8 overflow set", 32'(overflow_o), 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R8 overflow sticky", 32'(overflow_o), 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R8 overflow cleared", 32'(overflow_o), 0);

    // R4 order across pointer wrap; dropped data must not appear
    step(0, 0, 1, 0, 0, 0);
    chk_tx("R4 pop 5555", 16'h5555);
    for (int k = 1; k <= 5; k++) begin
      step(0, 0, 1, 0, 0, 0);
      chk_tx("R4 pop order", 16'h6000 + 16'(k));
    end
    chk("R7 empty after drain", 32'(empty_o), 1);
    step(0, 0, 1, 0, 0, 0);
    chk_tx("R8 dropped data absent", '0);
    chk("R5 underrun", 32'(underrun_o), 1);

    // R6 new underrun beats clear in same cycle
    step(0, 0, 1, 1, 0, 0);
    chk("R6 set wins", 32'(underrun_o), 1);
    step(0, 0, 0, 1, 0, 0);
    chk("R6 clear", 32'(underrun_o), 0);

    // R9 soft reset while running, with a write in the same cycle
    step(1, 16'h8888, 0, 0, 0, 0);
    step(1, 16'h9999, 0, 0, 0, 0);
    step(1, 16'hBBBB, 1, 0, 0, 1);
    chk("R9 count", 32'(count_o), 1);
    chk("R9 held", 32'(running_o), 0);
    chk("R9 flags", {29'd0, empty_o, underrun_o, overflow_o}, 0);
    chk_tx("R9 tx", '0);
    step(0, 0, 1, 0, 0, 0);
    chk("R2 held frame count", 32'(count_o), 1);
    chk("R2 held underrun", 32'(underrun_o), 0);

    // R3 restart; R4 primed zero first, ignored write absent
    step(1, 16'hAAAA, 0, 0, 0, 0);
    chk("R3 running", 32'(running_o), 1);
    chk("R3 count", 32'(count_o), 2);
    step(0, 0, 1, 0, 0, 0);
    chk_tx("R4 primed zero", '0);
    step(0, 0, 1, 0, 0, 0);
    chk_tx("R4 after restart", 16'hAAAA);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule